// File: doc/BRIEF.md
# Multi-queue DMA event dispatcher

This block takes in DMA event requests, each carrying a channel number and the index of one of four event queues, and holds them in four independent first-in, first-out queues. Each queue feeds exactly one transfer-controller port: queue N always feeds port N. All four queues share a single dequeue path, which stands for the one shared parameter-processing stage. That path therefore releases at most one event per clock.

In each cycle the dispatcher looks at the heads of the queues that hold an event and whose controller is ready. It picks one of them using a priority level that software programs for each queue. A lower level wins. When two levels are equal, the lower queue index wins. The chosen channel number appears one clock later on the shared output, together with its destination port and a valid flag. The priority levels live in an internal register that is loaded through a write strobe.

Top module: `evq_dispatch`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) empties every queue, clears `outValid` and every `qFull` bit, and loads each queue's priority field with its own index (queue 0 gets 0, queue 3 gets 3).
- R2: An accepted request is appended at the tail of the queue named by `reqQueue`. Each queue releases its events strictly in arrival order.
- R3: An event released from queue N always leaves with `outPort` equal to N.
- R4: A queue can be released in a cycle only if it holds at least one event and its bit of `tcReady` is 1 in that cycle.
- R5: Among the queues that can be released, the one whose 3-bit priority field (queue q at bits [3q+2:3q] of the priority register) has the smallest value is released.
- R6: When several queues that can be released share the smallest priority value, the lowest queue index wins.
- R7: At most one event is released per cycle. A release decided at a clock edge shows `outValid`=1 with its channel and port during the following cycle; otherwise `outValid` is 0.
- R8: Each queue holds 16 events, and its `qFull` bit is 1 exactly when it holds 16. A request to a queue whose `qFull` bit is set is dropped and leaves the stored events intact. The full check is made before any release in the same cycle.
- R9: A request accepted into a queue in the same cycle that the queue releases its head leaves that queue's occupancy unchanged.
- R10: A priority write (`priWrEn`=1 with `priWrData`) is captured at the clock edge. The arbitration in that same cycle still uses the old levels, and the new levels govern from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reqValid | input | 1 | Event request present |
| reqChan | input | CH_W | Channel number of the request |
| reqQueue | input | 2 | Target queue index of the request |
| qFull | output | 4 | Per-queue full flag |
| tcReady | input | 4 | Per-controller ready to take a request |
| priWrEn | input | 1 | Priority register write strobe |
| priWrData | input | 12 | New priority fields, 3 bits per queue |
| outValid | output | 1 | Dequeued event present |
| outChan | output | CH_W | Channel number of the dequeued event |
| outPort | output | 2 | Destination controller port |

## Verification
The arbiter is swept over all 256 priority settings built from the levels 0 to 3, with two events loaded into every queue and all controllers ready. This separates a strict ordering by level from the equal-level cases, where only the index tie-break can decide. A sweep of all fifteen non-zero ready masks, with every queue loaded, shows whether a queue whose controller is not ready is ever released. A single queue is filled past capacity and then drained, which shows both the refusal at 16 and that the order of the stored events survives the refused request. Separate sequences issue a priority write in the same cycle as a release and push into a queue while it is being drained. These tell a write that takes effect at once from one that takes effect a cycle later, and show whether occupancy drifts when a push and a release coincide.

// File: rtl/evq_pkg.sv
package evq_pkg;
  localparam int NQ     = 4;
  localparam int QIDX_W = 2;

  // Strobes from control to datapath
  typedef struct packed {
    logic [NQ-1:0]     push;
    logic [NQ-1:0]     pop;
    logic              popValid;
    logic [QIDX_W-1:0] popIdx;
  } evq_strobe_t;
endpackage

// File: rtl/evq_ctrl.sv
module evq_ctrl
  import evq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int PRI_W = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                reqValid,
  input  logic [QIDX_W-1:0]   reqQueue,
  input  logic [NQ-1:0]       tcReady,
  input  logic                priWrEn,
  input  logic [NQ*PRI_W-1:0] priWrData,
  output logic [NQ-1:0]       qFull,
  output evq_strobe_t         strobe
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [CNT_W-1:0]    count [NQ];
  logic [NQ*PRI_W-1:0] priReg;
  logic [PRI_W-1:0]    priLvl [NQ];
  logic [NQ-1:0]       eligible;
  logic [NQ-1:0]       pushMask;
  logic [NQ-1:0]       popMask;
  logic                popValid;
  logic [QIDX_W-1:0]   popIdx;
  logic [PRI_W-1:0]    bestPri;

  // Priority register: reset loads field q with value q
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int q = 0; q < NQ; q++) priReg[q*PRI_W +: PRI_W] <= PRI_W'(q);
    end else if (priWrEn) begin
      priReg <= priWrData;
    end
  end

  for (genvar q = 0; q < NQ; q++) begin : g_q
    assign priLvl[q]   = priReg[q*PRI_W +: PRI_W];
    assign qFull[q]    = (count[q] == CNT_W'(DEPTH));
    assign eligible[q] = (count[q] != '0) && tcReady[q];
    assign pushMask[q] = reqValid && (reqQueue == QIDX_W'(q)) && !qFull[q];
    assign popMask[q]  = popValid && (popIdx == QIDX_W'(q));

    always_ff @(posedge clk) begin
      if (rst) begin
        count[q] <= '0;
      end else begin
        case ({pushMask[q], popMask[q]})
          2'b10:   count[q] <= count[q] + 1'b1;
          2'b01:   count[q] <= count[q] - 1'b1;
          default: count[q] <= count[q];
        endcase
      end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
      count[q] <= CNT_W'(DEPTH)); // R8
    AST_PUSH_POP_HOLD: assert property (@(posedge clk) disable iff (rst)
      (pushMask[q] && popMask[q]) |=> $stable(count[q])); // R9
    AST_REFUSED_HOLD: assert property (@(posedge clk) disable iff (rst)
      (reqValid && reqQueue == QIDX_W'(q) && qFull[q] && !popMask[q])
        |=> (count[q] == CNT_W'(DEPTH))); // R8
  end

  // Arbiter: strictly lower level replaces, so ties keep the lower index
  always_comb begin
    popValid = 1'b0;
    popIdx   = '0;
    bestPri  = '1;
    for (int q = 0; q < NQ; q++) begin
      if (eligible[q] && (!popValid || priLvl[q] < bestPri)) begin
        popValid = 1'b1;
        popIdx   = QIDX_W'(q);
        bestPri  = priLvl[q];
      end
    end
  end

  assign strobe.push     = pushMask;
  assign strobe.pop      = popMask;
  assign strobe.popValid = popValid;
  assign strobe.popIdx   = popIdx;

  AST_ONE_POP: assert property (@(posedge clk) disable iff (rst)
    $onehot0(popMask)); // R7
endmodule

// File: rtl/evq_datapath.sv
module evq_datapath
  import evq_pkg::*;
#(
  parameter int CH_W  = 6,
  parameter int DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CH_W-1:0]   reqChan,
  input  evq_strobe_t       strobe,
  output logic              outValid,
  output logic [CH_W-1:0]   outChan,
  output logic [QIDX_W-1:0] outPort
);
  localparam int PTR_W = $clog2(DEPTH);

  logic [CH_W-1:0] headChan [NQ];

  for (genvar q = 0; q < NQ; q++) begin : g_fifo
    logic [CH_W-1:0]  mem [DEPTH];
    logic [PTR_W-1:0] wrPtr;
    logic [PTR_W-1:0] rdPtr;

    always_ff @(posedge clk) begin
      if (strobe.push[q]) mem[wrPtr] <= reqChan;
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        wrPtr <= '0;
        rdPtr <= '0;
      end else begin
        if (strobe.push[q]) wrPtr <= (wrPtr == PTR_W'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
        if (strobe.pop[q])  rdPtr <= (rdPtr == PTR_W'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
      end
    end

    assign headChan[q] = mem[rdPtr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid <= 1'b0;
      outChan  <= '0;
      outPort  <= '0;
    end else begin
      outValid <= strobe.popValid;
      if (strobe.popValid) begin
        outChan <= headChan[strobe.popIdx];
        outPort <= strobe.popIdx;
      end
    end
  end

  AST_OUT_FOLLOWS_POP: assert property (@(posedge clk) disable iff (rst)
    strobe.popValid |=> outValid); // R7
endmodule

// File: rtl/evq_dispatch.sv
module evq_dispatch
  import evq_pkg::*;
#(
  parameter int CH_W  = 6,
  parameter int DEPTH = 16,
  parameter int PRI_W = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                reqValid,
  input  logic [CH_W-1:0]     reqChan,
  input  logic [1:0]          reqQueue,
  output logic [3:0]          qFull,
  input  logic [3:0]          tcReady,
  input  logic                priWrEn,
  input  logic [4*PRI_W-1:0]  priWrData,
  output logic                outValid,
  output logic [CH_W-1:0]     outChan,
  output logic [1:0]          outPort
);
  evq_strobe_t strobe;
  logic [NQ-1:0] readyQ;

  evq_ctrl #(.DEPTH(DEPTH), .PRI_W(PRI_W)) u_ctrl (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqQueue(reqQueue),
    .tcReady(tcReady), .priWrEn(priWrEn), .priWrData(priWrData),
    .qFull(qFull), .strobe(strobe)
  );

  evq_datapath #(.CH_W(CH_W), .DEPTH(DEPTH)) u_dp (
    .clk(clk), .rst(rst), .reqChan(reqChan), .strobe(strobe),
    .outValid(outValid), .outChan(outChan), .outPort(outPort)
  );

  // Controller readiness one cycle back, for the release check
  always_ff @(posedge clk) begin
    if (rst) readyQ <= '0;
    else     readyQ <= tcReady;
  end

  AST_PORT_READY: assert property (@(posedge clk) disable iff (rst)
    outValid |-> readyQ[outPort]); // R4
endmodule

// File: tb/sim_evq_dispatch.sv
module sim_evq_dispatch;
  logic       clk = 1'b0;
  logic       rst;
  logic       reqValid;
  logic [5:0] reqChan;
  logic [1:0] reqQueue;
  logic [3:0] qFull;
  logic [3:0] tcReady;
  logic       priWrEn;
  logic [11:0] priWrData;
  logic       outValid;
  logic [5:0] outChan;
  logic [1:0] outPort;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // Reference state built from the requirements
  int mcnt [4];
  int mrp  [4];
  int mwp  [4];
  int mdat [4][16];
  int mpri [4];

  always #2.5 clk = ~clk;

  evq_dispatch u0 (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqChan(reqChan),
    .reqQueue(reqQueue), .qFull(qFull), .tcReady(tcReady),
    .priWrEn(priWrEn), .priWrData(priWrData), .outValid(outValid),
    .outChan(outChan), .outPort(outPort)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic modelReset();
    for (int q = 0; q < 4; q++) begin
      mcnt[q] = 0; mrp[q] = 0; mwp[q] = 0; mpri[q] = q;
    end
  endtask

  // One clock: predict, advance, compare
  task automatic step(string tag);
    int best = -1;
    int eChan = 0;
    for (int q = 0; q < 4; q++)
      if (mcnt[q] > 0 && tcReady[q] && (best < 0 || mpri[q] < mpri[best])) best = q;
    if (best >= 0) eChan = mdat[best][mrp[best]];
    if (reqValid && mcnt[reqQueue] < 16) begin
      mdat[reqQueue][mwp[reqQueue]] = int'(reqChan);
      mwp[reqQueue] = (mwp[reqQueue] + 1) % 16;
      mcnt[reqQueue]++;
    end
    if (best >= 0) begin
      mrp[best] = (mrp[best] + 1) % 16;
      mcnt[best]--;
    end
    if (priWrEn)
      for (int q = 0; q < 4; q++) mpri[q] = int'(priWrData[q*3 +: 3]);
    @(posedge clk); #1;
    chk({tag, "/R7 valid"}, int'(outValid), (best >= 0) ? 1 : 0);
    if (best >= 0) begin
      chk({tag, " chan"}, int'(outChan), eChan);
      chk({tag, "/R3 port"}, int'(outPort), best);
    end
    for (int q = 0; q < 4; q++)
      chk({tag, "/R8 full"}, int'(qFull[q]), (mcnt[q] == 16) ? 1 : 0);
  endtask

  task automatic idle();
    reqValid = 0; priWrEn = 0; tcReady = 4'h0;
  endtask

  task automatic push(int q, int ch, string tag);
    reqValid = 1; reqQueue = 2'(q); reqChan = 6'(ch);
    step(tag);
    reqValid = 0;
  endtask

  task automatic drain(string tag);
    tcReady = 4'hF;
    for (int i = 0; i < 70; i++) begin
      if (mcnt[0] + mcnt[1] + mcnt[2] + mcnt[3] == 0) break;
      step(tag);
    end
    step(tag);
    tcReady = 4'h0;
  endtask

  task automatic writePri(int p0, int p1, int p2, int p3, string tag);
    priWrEn = 1;
    priWrData = {3'(p3), 3'(p2), 3'(p1), 3'(p0)};
    step(tag);
    priWrEn = 0;
  endtask

  initial begin
    for (int i = 0; i < 150000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst = 1; idle(); reqChan = 0; reqQueue = 0; priWrData = 0;
    modelReset();
    repeat (3) @(posedge clk);
    #1; rst = 0;
    // R1: reset state
    chk("R1 outValid", int'(outValid), 0);
    chk("R1 qFull", int'(qFull), 0);

    // R1: default levels give order 0,1,2,3
    for (int q = 3; q >= 0; q--) push(q, 40 + q, "R1");
    drain("R1");

    // R8 / R2: fill queue 2 past capacity, then drain in order
    for (int i = 0; i < 18; i++) push(2, i * 3 + 1, "R8");
    chk("R8 full after overfill", int'(qFull[2]), 1);
    drain("R2");

    // R5 / R6: sweep all level settings drawn from 0..3
    for (int cfg = 0; cfg < 256; cfg++) begin
      int f0 = cfg & 3;
      int f1 = (cfg >> 2) & 3;
      int f2 = (cfg >> 4) & 3;
      int f3 = (cfg >> 6) & 3;
      bit tie = (f0 == f1) || (f0 == f2) || (f0 == f3) ||
                (f1 == f2) || (f1 == f3) || (f2 == f3);
      string tag = tie ? "R6" : "R5";
      writePri(f0, f1, f2, f3, tag);
      for (int k = 0; k < 2; k++)
        for (int q = 0; q < 4; q++) push(q, (cfg + q * 8 + k) & 63, tag);
      drain(tag);
    end

    // R4: every non-zero ready mask with all queues loaded
    writePri(3, 2, 1, 0, "R4");
    for (int m = 1; m < 16; m++) begin
      for (int q = 0; q < 4; q++) push(q, m * 4 + q, "R4");
      tcReady = 4'(m);
      for (int i = 0; i < 4; i++) step("R4");
      drain("R4");
    end

    // R10: write lands in same cycle as a release
    writePri(0, 1, 2, 3, "R10");
    push(0, 11, "R10"); push(0, 12, "R10"); push(3, 13, "R10");
    tcReady = 4'hF;
    writePri(7, 1, 2, 0, "R10");   // this cycle still releases queue 0
    step("R10");                    // now queue 3 wins
    drain("R10");

    // R9: push and release the same queue together
    for (int i = 0; i < 5; i++) push(1, 20 + i, "R9");
    tcReady = 4'b0010;
    for (int i = 0; i < 10; i++) push(1, 30 + i, "R9");
    tcReady = 4'h0;
    chk("R9 occupancy", mcnt[1], 5);
    drain("R9");

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule